// File: doc/BRIEF.md
# SPI Converter Command and Register Engine

This block is an SPI master that talks to a multichannel delta-sigma converter over its command port. A local client asks for one of three operations: a single-byte opcode command, a read of one register, or a write of one register. The engine turns the request into the serial frame, drives the clock, data-out and active-low select lines, and captures the returned data. When the frame is over it presents the received byte and pulses a done flag for one cycle.

The serial clock comes from dividing the system clock by a parameter. The divider must keep SCLK at or below the converter's 2.048 MHz master clock, because the converter needs four master clocks to decode each command byte. Running at that rate means no gap is needed between bytes. After the last bit, select stays low for a timed hold of about 2 µs, then it is released. Register reads and writes always carry a count byte of zero, so each access touches exactly one register. Requests that name a register above the highest implemented address are refused without touching the bus.

Top module: `adc_spi_cmd_eng`

## Requirements
- R1: After reset, cs_no is high, sclk_o is low, mosi_o is low, ready_o is high and done_o is low.
- R2: A command request (req_kind_i 0, and also the unused code 3) shifts out req_opc_i as exactly one byte, MSB first, using 8 SCLK pulses. rdata_o returns the byte received on MISO during that byte.
- R3: A read request (req_kind_i 1) sends three bytes: (0x20 OR req_addr_i), then 0x00, then 0x00. rdata_o is the byte received during the third byte time.
- R4: A write request (req_kind_i 2) sends three bytes: (0x40 OR req_addr_i), then 0x00, then req_wdata_i.
- R5: The bus runs in SPI mode 1. SCLK idles low, the engine changes MOSI on each rising SCLK edge, and it samples MISO on each falling edge.
- R6: Each SCLK half period lasts CLK_HALF system cycles. With the defaults (25 cycles at 100 MHz) the period is 500 ns, which is not faster than 2.048 MHz (488.28 ns).
- R7: After the last falling SCLK edge, cs_no stays low for CS_HOLD_CYC system cycles (2 µs by default, at least four 2.048 MHz clocks). It then goes high.
- R8: done_o is high for one cycle per finished request, and rdata_o is valid in that cycle. ready_o is low from the cycle after acceptance until the done cycle.
- R9: A req_valid_i pulse that arrives while ready_o is low has no effect. It does not change the frame in flight and does not start another transaction.
- R10: A read or write request whose address is above 0x19 never asserts cs_no. done_o rises in the cycle after acceptance, with rdata_o equal to 0x00.
- R11: Between transactions, cs_no is high and mosi_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when ready_o is high |
| req_kind_i | input | 2 | 0 command, 1 register read, 2 register write, 3 treated as command |
| req_opc_i | input | 8 | Opcode for a command request |
| req_addr_i | input | 5 | Register address for a read or write |
| req_wdata_i | input | 8 | Data byte for a write |
| ready_o | output | 1 | Engine idle and able to accept a request |
| done_o | output | 1 | One-cycle pulse when a request finishes |
| rdata_o | output | 8 | Received byte, valid with done_o |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
The bench uses a slave model that samples on the falling edge and drives on the rising edge. If the engine swapped its edges, every captured opcode and every returned byte would come out shifted by one bit. It checks the boundary address 0x19 against the refused addresses 0x1A and 0x1F. A wrong compare would either refuse a valid register or put a select pulse on the bus for a nonexistent one. It measures the time from the last falling SCLK edge to the rise of select, which would expose a hold counter that is short by one cycle. It also sends a request in the middle of a frame, which would expose an engine that re-latches its frame or queues a second transaction.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

  typedef enum logic [1:0] {
    REQ_CMD = 2'd0,
    REQ_RD  = 2'd1,
    REQ_WR  = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD
  } eng_state_e;

  localparam logic [7:0] OPC_RREG     = 8'h20;
  localparam logic [7:0] OPC_WREG     = 8'h40;
  localparam logic [4:0] REG_ADDR_MAX = 5'h19;
  localparam int         CMD_BITS     = 8;
  localparam int         REG_BITS     = 24;

endpackage

// File: rtl/adc_spi_tick.sv
// Half-period strobe for SCLK; restarts whenever run_i drops.
module adc_spi_tick #(
  parameter int HALF = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF > 1) begin : g_gap
      // R6: strobes are separated by at least one idle cycle
      p_tick_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/adc_spi_shreg.sv
// Transmit shifter (launch on drive_i) and receive byte (capture on sample_i).
module adc_spi_shreg #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         drive_i,
  input  logic         sample_i,
  input  logic         clr_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [7:0]   rx_byte_o
);
  logic [W-1:0] tx_q;
  logic         mosi_q;
  logic [7:0]   rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else if (load_i) begin
      tx_q   <= load_data_i;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (drive_i) begin
        mosi_q <= tx_q[W-1];
        tx_q   <= {tx_q[W-2:0], 1'b0};
      end
      if (sample_i) rx_q <= {rx_q[6:0], miso_i};
      if (clr_i)    mosi_q <= 1'b0;
    end
  end

  assign mosi_o    = mosi_q;
  assign rx_byte_o = rx_q;

  // R5: launch and capture never coincide with a new frame load
  p_load_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !drive_i && !sample_i);
  // R5: rising and falling edge actions never share a cycle
  p_edge_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_i && sample_i));

endmodule

// File: rtl/adc_spi_cmd_eng.sv
module adc_spi_cmd_eng
  import adc_spi_pkg::*;
#(
  parameter int CLK_HALF    = 25,
  parameter int CS_HOLD_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  input  logic [7:0] req_opc_i,
  input  logic [4:0] req_addr_i,
  input  logic [7:0] req_wdata_i,
  output logic       ready_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int BITS_W = $clog2(REG_BITS + 1);
  localparam int HOLD_W = (CS_HOLD_CYC > 1) ? $clog2(CS_HOLD_CYC) : 1;

  eng_state_e        state_q;
  logic              sclk_q, cs_nq, done_q;
  logic [7:0]        rdata_q;
  logic [BITS_W-1:0] bit_cnt_q, last_bit_q;
  logic [HOLD_W-1:0] hold_q;

  logic                is_rd, is_wr, is_cmd, addr_bad;
  logic                accept, load, tick, rise, fall, hold_end;
  logic [REG_BITS-1:0] frame;
  logic [7:0]          rx_byte;

  assign is_rd    = (req_kind_i == REQ_RD);
  assign is_wr    = (req_kind_i == REQ_WR);
  assign is_cmd   = !is_rd && !is_wr;
  assign addr_bad = !is_cmd && (req_addr_i > REG_ADDR_MAX);

  always_comb begin
    if (is_cmd)     frame = {req_opc_i, 16'h0000};
    else if (is_rd) frame = {OPC_RREG | {3'b000, req_addr_i}, 8'h00, 8'h00};
    else            frame = {OPC_WREG | {3'b000, req_addr_i}, 8'h00, req_wdata_i};
  end

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign load     = accept && !addr_bad;
  assign rise     = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign fall     = (state_q == ST_SHIFT) && tick && sclk_q;
  assign hold_end = (state_q == ST_HOLD) && (hold_q == HOLD_W'(CS_HOLD_CYC - 1));

  adc_spi_tick #(.HALF(CLK_HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SHIFT),
    .tick_o (tick)
  );

  adc_spi_shreg #(.W(REG_BITS)) u_shreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (frame),
    .drive_i     (rise),
    .sample_i    (fall),
    .clr_i       (hold_end),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_byte_o   (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sclk_q     <= 1'b0;
      cs_nq      <= 1'b1;
      done_q     <= 1'b0;
      rdata_q    <= '0;
      bit_cnt_q  <= '0;
      last_bit_q <= '0;
      hold_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (addr_bad) begin
            done_q  <= 1'b1;  // refused: bus untouched
            rdata_q <= '0;
          end else begin
            state_q    <= ST_SHIFT;
            cs_nq      <= 1'b0;
            bit_cnt_q  <= '0;
            last_bit_q <= is_cmd ? BITS_W'(CMD_BITS - 1) : BITS_W'(REG_BITS - 1);
          end
        end
        ST_SHIFT: begin
          if (rise) sclk_q <= 1'b1;
          if (fall) begin
            sclk_q    <= 1'b0;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == last_bit_q) begin
              state_q <= ST_HOLD;
              hold_q  <= '0;
            end
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            state_q <= ST_IDLE;
            cs_nq   <= 1'b1;
            done_q  <= 1'b1;
            rdata_q <= rx_byte;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_nq;

  p_idle_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);
  p_idle_mosi_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !mosi_o);
  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
  p_bit_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (bit_cnt_q <= last_bit_q));
  p_cs_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(state_q) == ST_HOLD);
  p_hold_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !sclk_o && !cs_no);

endmodule

// File: tb/adc_spi_cmd_eng_tb.sv
`timescale 1ns/1ps
module adc_spi_cmd_eng_tb;
  localparam int  CLK_HALF    = 25;
  localparam int  CS_HOLD_CYC = 200;
  localparam real MIN_PER_NS  = 488.28;
  localparam real HOLD_NS     = CS_HOLD_CYC * 10.0;

  // {kind[46:45], opc[44:37], addr[36:32], wdata[31:24], slave response[23:0]}
  localparam logic [46:0] VEC [8] = '{
    {2'd0, 8'h11, 5'h00, 8'h00, 24'hA5_0000},
    {2'd0, 8'h08, 5'h00, 8'h00, 24'h3C_FFFF},
    {2'd1, 8'h00, 5'h00, 8'h00, 24'h00_0092},
    {2'd1, 8'h00, 5'h19, 8'h00, 24'hFF_FF5A},
    {2'd2, 8'h00, 5'h01, 8'h86, 24'h00_0000},
    {2'd2, 8'h00, 5'h03, 8'hC0, 24'h55_AA55},
    {2'd3, 8'h0A, 5'h1F, 8'h00, 24'h69_0000},
    {2'd1, 8'h00, 5'h17, 8'h00, 24'h81_7EC3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_opc = '0, req_wdata = '0;
  logic [4:0] req_addr = '0;
  logic ready, done, sclk, cs_n, mosi;
  logic [7:0] rdata;
  logic miso = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [23:0] sl_resp = '0, mosi_cap = '0;
  int mosi_n = 0, rcnt = 0, cs_falls = 0;
  realtime t_fall = 0, t_rise_prev = 0, t_csrise = 0, min_per = 1.0e9;

  always #5 clk = ~clk;

  adc_spi_cmd_eng #(.CLK_HALF(CLK_HALF), .CS_HOLD_CYC(CS_HOLD_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_opc_i(req_opc), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  // Mode 1 slave: drives on rising edge, samples on falling edge
  always @(negedge cs_n) begin rcnt = 0; t_rise_prev = 0; cs_falls++; end
  always @(posedge cs_n) t_csrise = $realtime;
  always @(posedge sclk) begin
    if (t_rise_prev > 0 && ($realtime - t_rise_prev) < min_per) min_per = $realtime - t_rise_prev;
    t_rise_prev = $realtime;
    if (rcnt < 24) miso <= sl_resp[23 - rcnt];
    rcnt++;
  end
  always @(negedge sclk) begin
    mosi_cap = {mosi_cap[22:0], mosi};
    mosi_n++;
    t_fall = $realtime;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] kind, input logic [7:0] opc, input logic [4:0] addr,
                         input logic [7:0] wd, input logic [23:0] resp, input bit poke);
    logic [23:0] exp_frame;
    logic [7:0]  exp_rd;
    int exp_bits, guard, falls0;
    bit is_rd, is_wr;
    is_rd = (kind == 2'd1);
    is_wr = (kind == 2'd2);
    exp_bits  = (is_rd || is_wr) ? 24 : 8;
    exp_frame = is_rd ? {8'h20 | {3'b0, addr}, 16'h0000} :
                is_wr ? {8'h40 | {3'b0, addr}, 8'h00, wd} : {16'h0000, opc};
    exp_rd    = (is_rd || is_wr) ? resp[7:0] : resp[23:16];
    sl_resp = resp; mosi_cap = '0; mosi_n = 0; min_per = 1.0e9;
    falls0 = cs_falls;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_opc = opc; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!ready, "R8 ready low while busy", {31'b0, ready}, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd0; req_opc = 8'h06;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done, "R8 done seen", {31'b0, done}, 1);
    check(rdata == exp_rd, (is_rd || is_wr) ? "R3 rdata third byte" : "R2 rdata command byte", rdata, exp_rd);
    check(mosi_n == exp_bits, "R2 sclk pulse count", mosi_n, exp_bits);
    check(mosi_cap == exp_frame, is_wr ? "R4 write frame" : is_rd ? "R3 read frame" : "R2 command byte",
          mosi_cap, exp_frame);
    check(min_per >= MIN_PER_NS, "R6 sclk period", int'(min_per), int'(MIN_PER_NS));
    check(t_csrise - t_fall >= HOLD_NS, "R7 cs hold", int'(t_csrise - t_fall), int'(HOLD_NS));
    check(cs_falls == falls0 + 1, "R9 one frame per request", cs_falls, falls0 + 1);
    @(negedge clk);
    check(!done, "R8 done single cycle", {31'b0, done}, 0);
    check(cs_n && !mosi, "R11 bus idle after frame", {30'b0, cs_n, mosi}, 32'h2);
  endtask

  task automatic run_bad(input logic [1:0] kind, input logic [4:0] addr);
    int falls0;
    falls0 = cs_falls;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    check(done && rdata == 8'h00, "R10 refused address done", {23'b0, done, rdata}, 32'h100);
    repeat (100) @(negedge clk);
    check(cs_falls == falls0 && cs_n, "R10 no select for refused address", cs_falls, falls0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !mosi && ready && !done, "R1 reset outputs",
          {27'b0, cs_n, sclk, mosi, ready, done}, 32'h12);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !sclk && !mosi && ready && !done, "R1 state after release",
          {27'b0, cs_n, sclk, mosi, ready, done}, 32'h12);

    // R2 R3 R4 R5: table of frames; a slave on the wrong edges corrupts all of them
    for (int i = 0; i < 8; i++)
      run_txn(VEC[i][46:45], VEC[i][44:37], VEC[i][36:32], VEC[i][31:24], VEC[i][23:0], 1'b0);

    // R9: request pulsed mid-frame is ignored
    run_txn(2'd1, 8'h00, 5'h05, 8'h00, 24'h00_00E7, 1'b1);
    begin
      int f0;
      f0 = cs_falls;
      repeat (200) @(negedge clk);
      check(cs_falls == f0 && cs_n, "R9 no queued frame", cs_falls, f0);
    end

    // R10: addresses just above the last register
    run_bad(2'd1, 5'h1A);
    run_bad(2'd2, 5'h1F);
    // boundary register still served after refusals
    run_txn(2'd2, 8'h00, 5'h19, 8'h3B, 24'h00_0000, 1'b0);

    finish_run();
  end

endmodule